// File: doc/BRIEF.md
# Main and Clamp Gate Steering

This block converts the per-cycle pulse decision of a current-mode PWM loop into two gate commands: one for the main power switch and one for the active-clamp switch. Each switching cycle begins with a cycle-start strobe. The main pulse then ends on one of four events: the loop's terminate request, a peak-overcurrent flag (ignored for a leading-edge blanking interval), or the end of either of two maximum-duty windows. The first window is the fixed internal duty ceiling and the second is the input-voltage-dependent ceiling. The tighter of the two always wins.

The clamp command has two phasing modes. In non-overlap mode the clamp conducts while the main switch is off, and an equal dead time separates the two on both edges. In overlap mode the clamp command rises before the main command and falls after it by the same amount. This suits a clamp device whose gate is active low. A single delay count sets both edge delays, so they do not depend on frequency or duty. A synchronous-rectification mode adds a minimum main-pulse width. A global disable drops both gates to their safe levels at once. All timings are counted in clock cycles.

Top module: `gate_steer`

## Requirements
- R1: With `overlap_i`=0 and delay D captured at cycle start, `clamp_o` goes low at the first clock edge after the cycle start and `main_o` rises D edges later. After `main_o` falls, `clamp_o` rises D edges later. `main_o` and `clamp_o` are never high together in this mode.
- R2: With `overlap_i`=1, `clamp_o` goes high at the first clock edge after the cycle start and `main_o` rises D edges later. `clamp_o` falls D edges after `main_o` falls, and it is high whenever `main_o` is high.
- R3: With D=0, the selected phasing is kept with no delay. In non-overlap mode `clamp_o` is the exact complement of `main_o` during the cycle. In overlap mode it equals `main_o`.
- R4: With `sr_mode_i`=0, a terminate request seen while the main pulse is on drops `main_o` at the next edge. A cycle start seen together with a terminate request produces no pulse.
- R5: With `sr_mode_i`=1, a terminate request cannot make the main pulse shorter than MINPW_CYC cycles. A terminate held from the cycle start yields exactly MINPW_CYC cycles, and longer pulses are unchanged.
- R6: `oc_i` has no effect during the first BLANK_CYC cycles that `main_o` is high.
- R7: `oc_i` seen after blanking drops `main_o` at the next edge, even in synchronous-rectification mode before the minimum width. The main output then stays low for the rest of the switching cycle after `oc_i` clears.
- R8: A low level on either `win_int_i` or `win_vin_i` ends the main pulse at the next edge and overrides the minimum width.
- R9: While `disable_i` is high, `main_o` is 0 in that same cycle and `clamp_o` equals `overlap_i` (1 = inactive for overlap, 0 for non-overlap). After reset or disable, outputs hold those levels until a new cycle start.
- R10: A cycle start arriving while a lead delay, main pulse or trail delay is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disable_i | input | 1 | Global disable, forces safe gate levels |
| cyc_start_i | input | 1 | Switching-cycle start strobe |
| term_i | input | 1 | PWM terminate request |
| oc_i | input | 1 | Peak-overcurrent flag |
| win_int_i | input | 1 | Internal max-duty window, high while pulse allowed |
| win_vin_i | input | 1 | Input-voltage max-duty window, high while pulse allowed |
| sr_mode_i | input | 1 | 1 = synchronous-rectification mode (minimum pulse) |
| overlap_i | input | 1 | 1 = overlap phasing, 0 = non-overlap phasing |
| dly_i | input | DLY_W | Edge delay in clock cycles, captured at cycle start |
| main_o | output | 1 | Main switch gate command |
| clamp_o | output | 1 | Active-clamp gate command |

## Verification
In synchronous-rectification mode, the minimum-width clamp can be in force in the same cycle that a post-blanking overcurrent or a closing duty window demands termination. The bench holds the terminate request high from the cycle start and then raises the overcurrent flag, or drops one window, between the blanking limit and the minimum width. It judges the outcome by the measured main width, which must follow the overcurrent or window edge and not the minimum. A second pairing checks an overcurrent strobe inside the blanking interval while a terminate request is pending later. There the width must follow the terminate request alone.

// File: rtl/gate_steer_pkg.sv
package gate_steer_pkg;

  // Phase of the switching cycle as seen by the gate steering logic.
  typedef enum logic [2:0] {
    ST_HALT  = 3'd0,  // after reset or disable: gates at safe level
    ST_IDLE  = 3'd1,  // off phase of a running converter
    ST_LEAD  = 3'd2,  // edge delay before the main gate turns on
    ST_ON    = 3'd3,  // main gate on
    ST_TRAIL = 3'd4   // edge delay after the main gate turns off
  } gs_state_e;

  // Clamp level: the off phase of a running converter is the only state
  // where the clamp level differs from the phasing-mode level.
  function automatic logic clamp_level(gs_state_e st, logic overlap);
    return overlap ^ (st == ST_IDLE);
  endfunction

endpackage

// File: rtl/gs_dead_ctr.sv
module gs_dead_ctr #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             reload_i,
  input  logic             step_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             new_zero_o,
  output logic             held_zero_o,
  output logic             cnt_zero_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else if (arm_i) begin
      dly_q <= dly_i;
      cnt_q <= dly_i - ONE;
    end else if (reload_i) begin
      cnt_q <= dly_q - ONE;
    end else if (step_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign new_zero_o  = (dly_i == '0);
  assign held_zero_o = (dly_q == '0);
  assign cnt_zero_o  = (cnt_q == '0);

endmodule

// File: rtl/gs_on_timer.sv
module gs_on_timer #(
  parameter int BLANK_CYC = 25,
  parameter int MINPW_CYC = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic blank_done_o,
  output logic min_done_o
);
  localparam int MIN_LAST = (MINPW_CYC > 0) ? MINPW_CYC - 1 : 0;
  localparam int LIM      = (BLANK_CYC > MIN_LAST) ? BLANK_CYC : MIN_LAST;
  localparam int CNT_W    = $clog2(LIM + 2);
  localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(LIM);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(MIN_LAST);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // cnt_q equals the index of the current main-on cycle, saturating.
  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM_V) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign blank_done_o = (cnt_q >= BLANK_V);
  assign min_done_o   = (cnt_q >= MIN_V);

endmodule

// File: rtl/gs_phase_fsm.sv
module gs_phase_fsm
  import gate_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      disable_i,
  input  logic      cyc_start_i,
  input  logic      term_i,
  input  logic      oc_i,
  input  logic      win_ok_i,
  input  logic      sr_mode_i,
  input  logic      new_zero_i,
  input  logic      held_zero_i,
  input  logic      cnt_zero_i,
  input  logic      blank_done_i,
  input  logic      min_done_i,
  output gs_state_e st_q,
  output gs_state_e st_n,
  output logic      arm_o,
  output logic      reload_o,
  output logic      step_o
);
  logic zero_duty;
  logic end_req;

  // standard mode: a terminate request at start means zero duty
  assign zero_duty = term_i && !sr_mode_i;
  assign end_req   = !win_ok_i
                   || (oc_i && blank_done_i)
                   || (term_i && (!sr_mode_i || min_done_i));

  always_comb begin
    st_n     = st_q;
    arm_o    = 1'b0;
    reload_o = 1'b0;
    step_o   = 1'b0;
    unique case (st_q)
      ST_HALT, ST_IDLE: begin
        if (cyc_start_i && win_ok_i && !zero_duty) begin
          arm_o = 1'b1;
          st_n  = new_zero_i ? ST_ON : ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (!win_ok_i || zero_duty) begin
          st_n = ST_IDLE;
        end else if (cnt_zero_i) begin
          st_n = ST_ON;
        end else begin
          step_o = 1'b1;
        end
      end
      ST_ON: begin
        if (end_req) begin
          if (held_zero_i) begin
            st_n = ST_IDLE;
          end else begin
            reload_o = 1'b1;
            st_n     = ST_TRAIL;
          end
        end
      end
      ST_TRAIL: begin
        if (cnt_zero_i) st_n = ST_IDLE;
        else            step_o = 1'b1;
      end
      default: st_n = ST_HALT;
    endcase
    if (disable_i) begin
      st_n     = ST_HALT;
      arm_o    = 1'b0;
      reload_o = 1'b0;
      step_o   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_HALT;
    else     st_q <= st_n;
  end

endmodule

// File: rtl/gs_drive.sv
module gs_drive
  import gate_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  gs_state_e st_n,
  input  logic      overlap_i,
  input  logic      disable_i,
  output logic      main_o,
  output logic      clamp_o
);
  logic main_q;
  logic clamp_q;

  // outputs registered from the next state so they move with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q  <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      main_q  <= (st_n == ST_ON);
      clamp_q <= clamp_level(st_n, overlap_i);
    end
  end

  // disable overrides within the cycle it is raised
  assign main_o  = main_q && !disable_i;
  assign clamp_o = disable_i ? overlap_i : clamp_q;

endmodule

// File: rtl/gate_steer.sv
module gate_steer
  import gate_steer_pkg::*;
#(
  parameter int DLY_W     = 8,
  parameter int BLANK_CYC = 25,
  parameter int MINPW_CYC = 75
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disable_i,
  input  logic             cyc_start_i,
  input  logic             term_i,
  input  logic             oc_i,
  input  logic             win_int_i,
  input  logic             win_vin_i,
  input  logic             sr_mode_i,
  input  logic             overlap_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             main_o,
  output logic             clamp_o
);
  gs_state_e st_q;
  gs_state_e st_n;
  logic      win_ok;
  logic      arm;
  logic      reload;
  logic      step;
  logic      new_zero;
  logic      held_zero;
  logic      cnt_zero;
  logic      blank_done;
  logic      min_done;

  // the tighter of the two duty ceilings closes the window
  assign win_ok = win_int_i && win_vin_i;

  gs_dead_ctr #(.DLY_W(DLY_W)) u_dead (
    .clk        (clk),
    .rst        (rst),
    .arm_i      (arm),
    .reload_i   (reload),
    .step_i     (step),
    .dly_i      (dly_i),
    .new_zero_o (new_zero),
    .held_zero_o(held_zero),
    .cnt_zero_o (cnt_zero)
  );

  gs_on_timer #(.BLANK_CYC(BLANK_CYC), .MINPW_CYC(MINPW_CYC)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .run_i       (st_q == ST_ON),
    .blank_done_o(blank_done),
    .min_done_o  (min_done)
  );

  gs_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .disable_i   (disable_i),
    .cyc_start_i (cyc_start_i),
    .term_i      (term_i),
    .oc_i        (oc_i),
    .win_ok_i    (win_ok),
    .sr_mode_i   (sr_mode_i),
    .new_zero_i  (new_zero),
    .held_zero_i (held_zero),
    .cnt_zero_i  (cnt_zero),
    .blank_done_i(blank_done),
    .min_done_i  (min_done),
    .st_q        (st_q),
    .st_n        (st_n),
    .arm_o       (arm),
    .reload_o    (reload),
    .step_o      (step)
  );

  gs_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .st_n     (st_n),
    .overlap_i(overlap_i),
    .disable_i(disable_i),
    .main_o   (main_o),
    .clamp_o  (clamp_o)
  );

endmodule

// File: rtl/gate_steer_chk.sv
module gate_steer_chk #(
  parameter int BLANK_CYC = 25,
  parameter int MINPW_CYC = 75
) (
  input logic clk,
  input logic rst,
  input logic disable_i,
  input logic term_i,
  input logic oc_i,
  input logic win_int_i,
  input logic win_vin_i,
  input logic sr_mode_i,
  input logic overlap_i,
  input logic main_o,
  input logic clamp_o
);
  logic [15:0] hi_cnt;
  logic        win_ok;

  assign win_ok = win_int_i && win_vin_i;

  // width of the current or just-ended main pulse
  always_ff @(posedge clk) begin
    if (rst)                  hi_cnt <= '0;
    else if (!main_o)         hi_cnt <= '0;
    else if (hi_cnt != '1)    hi_cnt <= hi_cnt + 16'd1;
  end

  // R1
  nonovl_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !overlap_i |-> !(main_o && clamp_o));

  // R2
  ovl_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (overlap_i && main_o) |-> clamp_o);

  // R9
  dis_main_off_chk: assert property (@(posedge clk) disable iff (rst)
    disable_i |=> !main_o);

  // R5
  sr_min_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(main_o) && $past(sr_mode_i) && $past(win_ok) && !$past(oc_i)
     && !disable_i && !$past(disable_i)) |-> (hi_cnt >= 16'(MINPW_CYC)));

  // R6
  blank_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(main_o) && $past(win_ok) && !disable_i && !$past(disable_i)
     && (hi_cnt <= 16'(BLANK_CYC))) |-> $past(term_i));

endmodule

bind gate_steer gate_steer_chk #(.BLANK_CYC(BLANK_CYC), .MINPW_CYC(MINPW_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .disable_i(disable_i),
  .term_i   (term_i),
  .oc_i     (oc_i),
  .win_int_i(win_int_i),
  .win_vin_i(win_vin_i),
  .sr_mode_i(sr_mode_i),
  .overlap_i(overlap_i),
  .main_o   (main_o),
  .clamp_o  (clamp_o)
);

// File: tb/tb_gate_steer.sv
module tb_gate_steer;
  localparam int DLY_W = 8;
  localparam int BLANK = 25;
  localparam int MINPW = 75;
  localparam int L     = 250;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst = 1'b1;
  logic             disable_i = 1'b0;
  logic             cyc_start_i = 1'b0;
  logic             term_i = 1'b0;
  logic             oc_i = 1'b0;
  logic             win_int_i = 1'b1;
  logic             win_vin_i = 1'b1;
  logic             sr_mode_i = 1'b0;
  logic             overlap_i = 1'b0;
  logic [DLY_W-1:0] dly_i = '0;
  logic             main_o;
  logic             clamp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit main_s [L];
  bit clamp_s[L];

  gate_steer #(.DLY_W(DLY_W), .BLANK_CYC(BLANK), .MINPW_CYC(MINPW)) dut (
    .clk(clk), .rst(rst), .disable_i(disable_i), .cyc_start_i(cyc_start_i),
    .term_i(term_i), .oc_i(oc_i), .win_int_i(win_int_i), .win_vin_i(win_vin_i),
    .sr_mode_i(sr_mode_i), .overlap_i(overlap_i), .dly_i(dly_i),
    .main_o(main_o), .clamp_o(clamp_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One switching cycle; offsets are negedge indices, cycle start at 0.
  task automatic run_cycle(string req, bit ovl, bit sr, int d, int term_at,
                           int oc_at, int win_at, bit win_sel, int extra_at,
                           int exp_w);
    int rise, hi, bad_m, bad_c;
    bit env, exp_c;
    @(negedge clk);
    overlap_i = ovl; sr_mode_i = sr; dly_i = d[DLY_W-1:0];
    term_i = 1'b0; oc_i = 1'b0; win_int_i = 1'b1; win_vin_i = 1'b1;
    cyc_start_i = 1'b0;
    repeat (2) @(negedge clk);
    for (int n = 0; n < L; n++) begin
      if (n > 0) @(negedge clk);
      main_s[n]  = main_o;
      clamp_s[n] = clamp_o;
      cyc_start_i = (n == 0) || (n == extra_at);
      term_i      = (term_at >= 0) && (n >= term_at);
      oc_i        = (n == oc_at);
      win_int_i   = !((win_at >= 0) && (n >= win_at) && !win_sel);
      win_vin_i   = !((win_at >= 0) && (n >= win_at) && win_sel);
    end
    @(negedge clk);
    cyc_start_i = 1'b0; term_i = 1'b0; oc_i = 1'b0;
    win_int_i = 1'b1; win_vin_i = 1'b1;
    repeat (3) @(negedge clk);
    rise = 1 + d; hi = 0; bad_m = 0; bad_c = 0;
    for (int n = 1; n < L; n++) begin
      if (main_s[n]) hi++;
      if (main_s[n] != ((exp_w > 0) && (n >= rise) && (n < rise + exp_w))) bad_m++;
      if (exp_w > 0) begin
        env   = (n < rise + exp_w + d);
        exp_c = ovl ? env : !env;
      end else begin
        exp_c = !ovl;
      end
      if (clamp_s[n] != exp_c) bad_c++;
    end
    chk(req, "main width", hi, exp_w);
    chk(req, "main waveform mismatches", bad_m, 0);
    chk(req, "clamp waveform mismatches", bad_c, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "reset main", main_o, 0);
    chk("R9", "reset clamp", clamp_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "halt main", main_o, 0);
    chk("R9", "halt clamp", clamp_o, 0);
  endtask

  task automatic t_nonoverlap();   // R1
    run_cycle("R1", 1'b0, 1'b0, 4, 40, -1, -1, 1'b0, -1, 36);
  endtask

  task automatic t_overlap();      // R2
    run_cycle("R2", 1'b1, 1'b0, 6, 50, -1, -1, 1'b0, -1, 44);
  endtask

  task automatic t_zero_delay();   // R3
    run_cycle("R3", 1'b0, 1'b0, 0, 20, -1, -1, 1'b0, -1, 20);
    run_cycle("R3", 1'b1, 1'b0, 0, 30, -1, -1, 1'b0, -1, 30);
  endtask

  task automatic t_zero_duty();    // R4
    run_cycle("R4", 1'b0, 1'b0, 3, 0, -1, -1, 1'b0, -1, 0);
  endtask

  task automatic t_min_pulse();    // R5
    run_cycle("R5", 1'b0, 1'b1, 3, 0, -1, -1, 1'b0, -1, MINPW);
    run_cycle("R5", 1'b1, 1'b1, 3, 100, -1, -1, 1'b0, -1, 97);
  endtask

  task automatic t_blanking();     // R6
    run_cycle("R6", 1'b0, 1'b0, 4, 60, 10, -1, 1'b0, -1, 56);
  endtask

  task automatic t_peak_cut();     // R7
    run_cycle("R7", 1'b0, 1'b0, 4, 150, 40, -1, 1'b0, -1, 36);
    run_cycle("R7", 1'b0, 1'b1, 3, 0, 40, -1, 1'b0, -1, 37);
  endtask

  task automatic t_window();       // R8
    run_cycle("R8", 1'b0, 1'b0, 2, 120, -1, 30, 1'b0, -1, 28);
    run_cycle("R8", 1'b1, 1'b1, 2, 0, -1, 25, 1'b1, -1, 23);
  endtask

  task automatic t_busy_start();   // R10
    run_cycle("R10", 1'b0, 1'b0, 4, 60, -1, -1, 1'b0, 20, 56);
  endtask

  task automatic t_disable();      // R9
    @(negedge clk);
    overlap_i = 1'b0; sr_mode_i = 1'b0; dly_i = 8'd4;
    cyc_start_i = 1'b1;
    @(negedge clk);
    cyc_start_i = 1'b0;
    repeat (18) @(negedge clk);
    chk("R9", "main on before disable", main_o, 1);
    disable_i = 1'b1;
    #1;
    chk("R9", "main same cycle", main_o, 0);
    chk("R9", "clamp same cycle", clamp_o, 0);
    @(negedge clk);
    cyc_start_i = 1'b1;
    @(negedge clk);
    cyc_start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "start ignored under disable", main_o, 0);
    overlap_i = 1'b1;
    #1;
    chk("R9", "overlap inactive clamp", clamp_o, 1);
    @(negedge clk);
    overlap_i = 1'b0;
    disable_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9", "halt holds main", main_o, 0);
    chk("R9", "halt holds clamp", clamp_o, 0);
    cyc_start_i = 1'b1;
    @(negedge clk);
    cyc_start_i = 1'b0;
    term_i = 1'b1;
    repeat (10) @(negedge clk);
    term_i = 1'b0;
    chk("R9", "idle clamp after restart", clamp_o, 1);
    disable_i = 1'b1;
    #1;
    chk("R9", "idle clamp forced off", clamp_o, 0);
    @(negedge clk);
    disable_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_nonoverlap();
    t_overlap();
    t_zero_delay();
    t_zero_duty();
    t_min_pulse();
    t_blanking();
    t_peak_cut();
    t_window();
    t_busy_start();
    t_disable();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule